// File: doc/BRIEF.md
# Framed Data Packet Receiver

This block sits on the host side of a byte-serial link and handles the data phase of a block read after the command exchange has completed. A caller supplies a byte count, a packet-size selector and a CRC16 enable, then pulses `start`. The receiver consumes bytes from an upstream byte shifter. Before every packet it skips filler bytes until it sees a start tag. It then forwards that packet's payload on a valid/ready stream. When CRC16 is enabled it also checks the two-byte trailer that follows each packet.

Long transfers are split into packets of a power-of-two size. Each packet carries its own tag and its own CRC. The transfer ends with exactly one of three one-cycle pulses: normal completion, missing tag, or CRC mismatch. Payload already forwarded before an error is not withdrawn. While it clocks data in, the receiver presents an all-zero transmit byte to the shifter. A four-byte single register read is the same operation with a count of 4.

Top module: `fprx_top`

## Requirements
- R1: After reset, and whenever no transfer is running, `busy`, `in_ready`, `out_valid`, `done`, `err_tag` and `err_crc` are all 0.
- R2: While hunting, a byte whose upper nibble is not 0xF is discarded. The first byte whose upper nibble is 0xF (for example 0xF3) is the start tag. No hunt byte is ever forwarded.
- R3: If HUNT_LIMIT (8) consecutive hunt bytes arrive without a tag, `err_tag` pulses and the transfer ends. A tag arriving as the 8th hunt byte (after 7 fillers) is accepted.
- R4: The packet size is 2^(8+`pkt_sel`) bytes, and selector values above 5 are clamped to 8192 bytes. Each packet carries min(bytes remaining, packet size) payload bytes, and every packet begins with its own tag hunt.
- R5: Payload bytes leave on `out_data` in arrival order, with their count equal to `total_len`. During payload, `in_ready` follows `out_ready`, so a stalled output holds the stream.
- R6: With `crc_en`=1, every packet is followed by two trailer bytes, high byte first. These must equal CRC-ITU-T (polynomial 0x1021, seed 0xFFFF, MSB first, no final XOR) computed over that packet's payload only. Trailer bytes are not forwarded.
- R7: On a trailer mismatch, `err_crc` pulses and the transfer ends. Bytes already delivered stay delivered, and no further input byte is consumed.
- R8: With `crc_en`=0, no trailer is consumed. The byte after a packet is treated as a hunt byte, and after the last packet nothing more is consumed. This mode serves clockless register reads.
- R9: `done` pulses for one cycle in the cycle after the last byte of a successful transfer is accepted. Exactly one of `done`, `err_tag` and `err_crc` pulses per transfer, and `busy` is 0 whenever any of them is high.
- R10: `tx_byte` is 0x00 at all times.
- R11: `start` is ignored while `busy` is 1. A `start` with `total_len`=0 produces `done` in the next cycle and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| total_len | input | LEN_W | Payload bytes to receive |
| pkt_sel | input | 3 | Packet size selector, log2(size)-8 |
| crc_en | input | 1 | Expect and check CRC16 trailers |
| in_valid | input | 1 | Upstream byte available |
| in_byte | input | 8 | Upstream byte |
| in_ready | output | 1 | Byte consumed this cycle when valid |
| tx_byte | output | 8 | Dummy byte to shift out (always zero) |
| out_valid | output | 1 | Payload byte available |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream accepts payload |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle successful-completion pulse |
| err_tag | output | 1 | One-cycle missing-tag pulse |
| err_crc | output | 1 | One-cycle CRC-mismatch pulse |

## Verification
The stall assertion assumes the upstream source keeps `in_valid` high and `in_byte` unchanged until the byte is consumed. The bench honours this by driving only from a prepared byte queue that advances solely on an accepted handshake. The payload-count check assumes `total_len` is sampled only at an idle `start`. To respect that, the bench pulses a conflicting `start` mid-transfer and confirms that the delivered data and the ending still follow the original request. Filler bytes are drawn only from values whose upper nibble is below 0xF, so a filler can never be read as a tag.

// File: rtl/fprx_pkg.sv
package fprx_pkg;

    localparam logic [3:0] TAG_NIBBLE = 4'hF;
    localparam logic [7:0] IDLE_TX    = 8'h00;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY  = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_BODY,
        ST_CRC_HI,
        ST_CRC_LO
    } rx_state_e;

    typedef struct packed {
        logic ok;
        logic no_tag;
        logic bad_crc;
    } rx_end_t;

    // One byte of CRC-ITU-T, MSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                               input logic [7:0]  d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/fprx_crc16.sv
module fprx_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    import fprx_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= CRC_SEED;
        else if (upd)
            crc <= crc16_step(crc, data);
    end
endmodule

// File: rtl/fprx_ctrl.sv
module fprx_ctrl #(
    parameter int LEN_W       = 16,
    parameter int PKT_LOG_MIN = 8,
    parameter int PKT_LOG_MAX = 13,
    parameter int HUNT_LIMIT  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [2:0]       pkt_sel,
    input  logic             crc_en,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             out_ready,
    input  logic [15:0]      crc_val,
    output logic             in_ready,
    output logic             out_valid,
    output logic             crc_clr,
    output logic             crc_upd,
    output logic             busy,
    output fprx_pkg::rx_end_t fin
);
    import fprx_pkg::*;

    localparam int PKT_W   = PKT_LOG_MAX + 1;
    localparam int CW      = (LEN_W > PKT_W) ? LEN_W : PKT_W;
    localparam int HUNT_W  = $clog2(HUNT_LIMIT + 1);
    localparam int SEL_MAX = PKT_LOG_MAX - PKT_LOG_MIN;

    rx_state_e         state_q;
    logic [LEN_W-1:0]  rem_q;
    logic [CW-1:0]     left_q;
    logic [CW-1:0]     psize_q;
    logic [HUNT_W-1:0] hunt_q;
    logic              crc_on_q;
    logic [7:0]        hi_q;

    logic          acc;
    logic          is_tag;
    logic [2:0]    sel_c;
    logic [CW-1:0] rem_w;
    logic [CW-1:0] chunk;

    always_comb begin
        busy      = (state_q != ST_IDLE);
        in_ready  = busy && ((state_q != ST_BODY) || out_ready);
        out_valid = (state_q == ST_BODY) && in_valid;
        acc       = in_valid && in_ready;
        is_tag    = (in_byte[7:4] == TAG_NIBBLE);
        crc_clr   = (state_q == ST_HUNT) && acc && is_tag;
        crc_upd   = (state_q == ST_BODY) && acc;
        sel_c     = (int'(pkt_sel) > SEL_MAX) ? 3'(SEL_MAX) : pkt_sel;
        rem_w     = CW'(rem_q);
        chunk     = (rem_w < psize_q) ? rem_w : psize_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            rem_q    <= '0;
            left_q   <= '0;
            psize_q  <= '0;
            hunt_q   <= '0;
            crc_on_q <= 1'b0;
            hi_q     <= '0;
            fin      <= '0;
        end else begin
            fin <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        crc_on_q <= crc_en;
                        psize_q  <= CW'(1) << (PKT_LOG_MIN + int'(sel_c));
                        rem_q    <= total_len;
                        hunt_q   <= '0;
                        if (total_len == '0)
                            fin.ok <= 1'b1;
                        else
                            state_q <= ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (acc) begin
                        if (is_tag) begin
                            left_q  <= chunk;
                            hunt_q  <= '0;
                            state_q <= ST_BODY;
                        end else if (int'(hunt_q) == HUNT_LIMIT - 1) begin
                            fin.no_tag <= 1'b1;
                            state_q    <= ST_IDLE;
                        end else begin
                            hunt_q <= hunt_q + 1'b1;
                        end
                    end
                end
                ST_BODY: begin
                    if (acc) begin
                        rem_q  <= rem_q - 1'b1;
                        left_q <= left_q - 1'b1;
                        if (left_q == CW'(1)) begin
                            if (crc_on_q)
                                state_q <= ST_CRC_HI;
                            else if (rem_q == LEN_W'(1)) begin
                                fin.ok  <= 1'b1;
                                state_q <= ST_IDLE;
                            end else
                                state_q <= ST_HUNT;
                        end
                    end
                end
                ST_CRC_HI: begin
                    if (acc) begin
                        hi_q    <= in_byte;
                        state_q <= ST_CRC_LO;
                    end
                end
                ST_CRC_LO: begin
                    if (acc) begin
                        if ({hi_q, in_byte} != crc_val) begin
                            fin.bad_crc <= 1'b1;
                            state_q     <= ST_IDLE;
                        end else if (rem_q == '0) begin
                            fin.ok  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else
                            state_q <= ST_HUNT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fprx_top.sv
module fprx_top #(
    parameter int LEN_W       = 16,
    parameter int PKT_LOG_MIN = 8,
    parameter int PKT_LOG_MAX = 13,
    parameter int HUNT_LIMIT  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [2:0]       pkt_sel,
    input  logic             crc_en,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic [7:0]       tx_byte,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             busy,
    output logic             done,
    output logic             err_tag,
    output logic             err_crc
);
    import fprx_pkg::*;

    logic      crc_clr;
    logic      crc_upd;
    logic [15:0] crc_val;
    rx_end_t   fin;

    fprx_ctrl #(
        .LEN_W       (LEN_W),
        .PKT_LOG_MIN (PKT_LOG_MIN),
        .PKT_LOG_MAX (PKT_LOG_MAX),
        .HUNT_LIMIT  (HUNT_LIMIT)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .total_len (total_len),
        .pkt_sel   (pkt_sel),
        .crc_en    (crc_en),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .out_ready (out_ready),
        .crc_val   (crc_val),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .crc_clr   (crc_clr),
        .crc_upd   (crc_upd),
        .busy      (busy),
        .fin       (fin)
    );

    fprx_crc16 crc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .upd  (crc_upd),
        .data (in_byte),
        .crc  (crc_val)
    );

    assign out_data = in_byte;
    assign tx_byte  = IDLE_TX;
    assign done     = fin.ok;
    assign err_tag  = fin.no_tag;
    assign err_crc  = fin.bad_crc;
endmodule

// File: rtl/fprx_checker.sv
module fprx_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] total_len,
    input logic             busy,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_byte,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             done,
    input logic             err_tag,
    input logic             err_crc
);
    logic [LEN_W:0] sent_q;
    logic [LEN_W:0] want_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q <= '0;
            want_q <= '0;
        end else if (start && !busy) begin
            sent_q <= '0;
            want_q <= {1'b0, total_len};
        end else if (out_valid && out_ready) begin
            sent_q <= sent_q + 1'b1;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!in_ready && !out_valid));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        sent_q <= want_q);

    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r9_one_ending: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err_tag, err_crc}));

    a_r9_end_idle: assert property (@(posedge clk) disable iff (rst)
        (done || err_tag || err_crc) |-> !busy);

    a_r3_tag_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_tag |-> ($past(in_byte[7:4]) != 4'hF));
endmodule

bind fprx_top fprx_checker #(.LEN_W(LEN_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .total_len (total_len),
    .busy      (busy),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .err_tag   (err_tag),
    .err_crc   (err_crc)
);

// File: tb/fprx_top_tb_top.sv
module fprx_top_tb_top;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [LEN_W-1:0] total_len = '0;
    logic [2:0]       pkt_sel = '0;
    logic             crc_en = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = '0;
    logic             in_ready;
    logic [7:0]       tx_byte;
    logic             out_valid;
    logic [7:0]       out_data;
    logic             out_ready = 1'b0;
    logic             busy;
    logic             done;
    logic             err_tag;
    logic             err_crc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [7:0] stream_q[$];
    logic [7:0] expect_q[$];

    fprx_top #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .total_len(total_len),
        .pkt_sel(pkt_sel), .crc_en(crc_en), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .tx_byte(tx_byte),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done), .err_tag(err_tag), .err_crc(err_crc)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    // fill < 0: filler count varies per packet (p % 8)
    task automatic build(input int len, input int sel, input bit use_crc,
                         input int fill, input int bad_pkt,
                         output int cons, output int kind);
        int rem, p, psz, nf, n;
        logic [15:0] c;
        logic [7:0] b;
        stream_q.delete();
        expect_q.delete();
        rem = len; p = 0; cons = 0; kind = 0;
        psz = 1 << (8 + ((sel > 5) ? 5 : sel));
        while (rem > 0) begin
            nf = (fill < 0) ? (p % 8) : fill;
            for (int i = 0; i < nf; i++) stream_q.push_back(8'($urandom % 240));
            if (nf >= 8) begin
                cons += 8; kind = 1;
                break;
            end
            cons += nf;
            stream_q.push_back(8'hF0 | 8'($urandom % 16));
            cons++;
            n = (rem < psz) ? rem : psz;
            c = 16'hFFFF;
            for (int i = 0; i < n; i++) begin
                b = 8'($urandom);
                stream_q.push_back(b);
                expect_q.push_back(b);
                c = ref_crc(c, b);
            end
            cons += n;
            rem -= n;
            if (use_crc) begin
                if (p == bad_pkt) c = c ^ 16'h0100;
                stream_q.push_back(c[15:8]);
                stream_q.push_back(c[7:0]);
                cons += 2;
                if (p == bad_pkt) begin
                    kind = 2;
                    break;
                end
            end
            p++;
        end
        for (int i = 0; i < 4; i++) stream_q.push_back(8'hF3);
    endtask

    task automatic feed_head();
        in_valid = (stream_q.size() > 0);
        in_byte  = (stream_q.size() > 0) ? stream_q[0] : 8'h00;
    endtask

    task automatic run(input string req, input int len, input int sel,
                       input bit use_crc, input int fill, input int bad_pkt,
                       input bit poke);
        int exp_cons, exp_kind, got_kind, cons, it;
        bit take, seen;
        build(len, sel, use_crc, fill, bad_pkt, exp_cons, exp_kind);
        cons = 0; it = 0; seen = 0; got_kind = -1;
        @(negedge clk);
        feed_head();
        total_len = LEN_W'(len); pkt_sel = 3'(sel); crc_en = use_crc;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        while (!seen) begin
            @(negedge clk);
            chk(tx_byte == 8'h00, "R10", "tx_byte", tx_byte, 0);
            if (done || err_tag || err_crc) begin
                got_kind = done ? 0 : (err_tag ? 1 : 2);
                chk(!busy, "R9", "busy at end", busy, 0);
                seen = 1;
            end else begin
                if (out_valid && out_ready) begin
                    if (expect_q.size() == 0)
                        chk(0, "R5", "extra payload", out_data, -1);
                    else begin
                        chk(out_data == expect_q[0], "R5", "payload byte", out_data, expect_q[0]);
                        void'(expect_q.pop_front());
                    end
                end
                take = in_valid && in_ready;
                @(posedge clk); #1;
                if (take) begin
                    void'(stream_q.pop_front());
                    cons++;
                end
                feed_head();
                out_ready = ($urandom % 4) != 0;
                start = 1'b0;
                if (poke && it == 5) begin
                    start = 1'b1;
                    total_len = LEN_W'(3);
                end else
                    total_len = LEN_W'(len);
                it++;
            end
        end
        start = 1'b0;
        chk(got_kind == exp_kind, req, "ending kind", got_kind, exp_kind);
        chk(cons == exp_cons, req, "bytes consumed", cons, exp_cons);
        chk(expect_q.size() == 0, req, "payload missing", expect_q.size(), 0);
        @(negedge clk);
        chk(!busy && !in_ready && !done && !err_tag && !err_crc, "R1",
            "idle after end", {busy, in_ready, done, err_tag, err_crc}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !in_ready && !out_valid && !done && !err_tag && !err_crc,
            "R1", "reset state", {busy, in_ready, out_valid, done, err_tag, err_crc}, 0);
        chk(tx_byte == 8'h00, "R10", "tx_byte reset", tx_byte, 0);

        run("R8", 20, 0, 1'b0, 0, -1, 1'b0);        // no trailer, single packet
        run("R6", 4, 0, 1'b1, 3, -1, 1'b0);         // register-sized read with CRC
        run("R4", 600, 0, 1'b1, 2, -1, 1'b0);       // three 256-byte-class packets
        run("R2", 600, 0, 1'b0, -1, -1, 1'b0);      // varying fillers, no CRC
        run("R3", 50, 0, 1'b1, 7, -1, 1'b0);        // 7 fillers: tag still found
        run("R3", 50, 0, 1'b1, 8, -1, 1'b0);        // 8 fillers: missing tag
        run("R7", 600, 0, 1'b1, 1, 1, 1'b0);        // bad CRC on second packet
        run("R4", 9000, 7, 1'b1, 1, -1, 1'b0);      // clamp to 8192
        run("R8", 512, 1, 1'b0, 0, -1, 1'b0);       // exact single packet
        run("R11", 0, 0, 1'b1, 0, -1, 1'b0);        // zero length
        run("R11", 300, 0, 1'b1, 2, -1, 1'b1);      // start ignored while busy
        run("R9", 260, 0, 1'b1, 4, -1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule